// File: doc/BRIEF.md
# Interrupt Latch and Context Stacker

This block sits beside a small 8-bit processor core and decides when an interrupt is taken. Every maskable source has its own pending latch, and a software trap has one too. A single global mask bit, held by the core, blocks the maskable sources. The trap ignores the mask. When a request is accepted, the block writes the core's context to the stack one byte per cycle. It asserts a push strobe on each of those cycles, reports which vector was taken, and tells the core to set its mask once the condition code byte has been written.

A return command runs the stack sequence the other way. The block issues five pop strobes in a row. Each byte read back is then handed to the core with a tag naming the register it belongs to. While either sequence is running, the core is stalled by a busy flag. The block does not move the stack pointer: the surrounding logic decrements it on each push and increments it on each pop.

Top module: `irq_ctx_stacker`

## Requirements
- R1: After reset, busy_o, stk_we_o, stk_re_o, ld_valid_o, vec_valid_o and set_mask_o are all low, and no source is pending.
- R2: A maskable request is latched whenever irq_req_i is high at a clock edge. While mask_i is high it is not accepted. It is accepted once mask_i is low.
- R3: A trap request is accepted even while mask_i is high. A pending trap wins over every pending maskable source. It is reported as vector index N_SRC.
- R4: When several maskable sources are pending and mask_i is low, the lowest source index is accepted first.
- R5: Repeated requests from one source before it is serviced merge into a single pending request, which causes exactly one entry sequence.
- R6: Each entry makes five push cycles in a row. stk_we_o is high on each of them. stk_wdata_o carries PC[7:0], then PC[15:8], then X, then A, then CC. The values are those present on the context inputs in the cycle the request was accepted.
- R7: set_mask_o is high for exactly one cycle per entry, in the same cycle as the CC push.
- R8: The accepted source's pending latch is cleared at the clock edge that ends the accept cycle. A request on that same edge sets the latch again (set wins), which causes a second entry later.
- R9: When ret_i is high in an idle cycle, stk_re_o is high for five cycles in a row. Each pop is followed one cycle later by ld_valid_o, with ld_data_o equal to stk_rdata_i. ld_sel_o takes the codes CC=0, A=1, X=2, PCH=3, PCL=4, in that order.
- R10: busy_o is high from the cycle after an accept or a return command until the last push, or the cycle of the last load. ret_i is ignored while busy_o is high. Requests that arrive while busy are latched.
- R11: If ret_i is high in an idle cycle in which a request could be accepted, the return runs first and the request stays pending.
- R12: vec_valid_o pulses in the cycle of the first push. vec_o holds the accepted index from that cycle until the next accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | N_SRC | Maskable request lines, one per source |
| trap_req_i | input | 1 | Software trap request |
| mask_i | input | 1 | Core's global interrupt mask |
| ret_i | input | 1 | Return command: restore context from stack |
| acc_i | input | 8 | Current accumulator |
| xr_i | input | 8 | Current X index register |
| cc_i | input | 8 | Current condition code register |
| pc_i | input | 16 | Current program counter |
| stk_rdata_i | input | 8 | Stack read data, valid the cycle after a pop strobe |
| stk_we_o | output | 1 | Push strobe |
| stk_wdata_o | output | 8 | Push data byte |
| stk_re_o | output | 1 | Pop strobe |
| ld_valid_o | output | 1 | Restored byte valid |
| ld_sel_o | output | 3 | Register code of the restored byte |
| ld_data_o | output | 8 | Restored byte |
| vec_valid_o | output | 1 | Accept report pulse |
| vec_o | output | VEC_W | Accepted vector index (N_SRC = trap) |
| set_mask_o | output | 1 | Tells the core to set its mask |
| busy_o | output | 1 | Sequence in progress |

## Verification
The case of interest is a new request landing on the same edge that clears that source's pending latch. The bench holds a request line high across two edges: the first sets the latch, and the second is the accept edge itself. The bench then expects that vector to be serviced twice, and an extra or missing entry counts as a failure. A second collision puts a return command in the very cycle a pending source would be accepted. The bench expects the five restored bytes first, and only after them the entry for that source.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int BYTE_W    = 8;
  localparam int PC_W      = 2 * BYTE_W;
  localparam int CTX_BYTES = 5;
  localparam int SEL_W     = $clog2(CTX_BYTES);
  localparam int STEP_W    = $clog2(CTX_BYTES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_PUSH, ST_POP} seq_st_t;

  // Register codes; pop order runs 0..4, push order runs 4..0
  localparam logic [SEL_W-1:0] SEL_CC  = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_A   = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_X   = SEL_W'(2);
  localparam logic [SEL_W-1:0] SEL_PCH = SEL_W'(3);
  localparam logic [SEL_W-1:0] SEL_PCL = SEL_W'(4);

  typedef struct packed {
    logic [BYTE_W-1:0] cc;
    logic [BYTE_W-1:0] a;
    logic [BYTE_W-1:0] x;
    logic [PC_W-1:0]   pc;
  } ctx_t;

  function automatic logic [BYTE_W-1:0] ctx_byte(ctx_t c, logic [SEL_W-1:0] sel);
    logic [BYTE_W-1:0] b;
    case (sel)
      SEL_CC:  b = c.cc;
      SEL_A:   b = c.a;
      SEL_X:   b = c.x;
      SEL_PCH: b = c.pc[PC_W-1:BYTE_W];
      default: b = c.pc[BYTE_W-1:0];
    endcase
    return b;
  endfunction
endpackage

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  // One latch per source; a set on the clearing edge wins
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic pend_d, pend_q;

    always_comb begin
      pend_d = pend_q;
      if (clr_i[g]) pend_d = 1'b0;
      if (set_i[g]) pend_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= pend_d;
    end

    assign pend_o[g] = pend_q;
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N_SRC = 4,
  localparam int VEC_W = $clog2(N_SRC + 1)
) (
  input  logic [N_SRC:0]   pend_i,   // bit N_SRC is the trap
  input  logic             mask_i,
  output logic             any_o,
  output logic [VEC_W-1:0] idx_o,
  output logic [N_SRC:0]   onehot_o
);
  logic             mk_any;
  logic [VEC_W-1:0] mk_idx;

  // Walk downward so the lowest pending index is the last one written
  always_comb begin
    mk_any = 1'b0;
    mk_idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        mk_any = 1'b1;
        mk_idx = VEC_W'(i);
      end
    end
  end

  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    if (pend_i[N_SRC]) begin
      any_o = 1'b1;
      idx_o = VEC_W'(N_SRC);
    end else if (!mask_i && mk_any) begin
      any_o = 1'b1;
      idx_o = mk_idx;
    end
  end

  assign onehot_o = any_o ? ((N_SRC + 1)'(1) << idx_o) : '0;
endmodule

// File: rtl/ctx_seq.sv
module ctx_seq
  import irq_pkg::*;
#(
  parameter int VEC_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_i,
  input  logic [VEC_W-1:0]  idx_i,
  input  logic              ret_i,
  input  ctx_t              ctx_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              grant_o,
  output logic              we_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              re_o,
  output logic              ld_valid_o,
  output logic [SEL_W-1:0]  ld_sel_o,
  output logic [BYTE_W-1:0] ld_data_o,
  output logic              vec_valid_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              set_mask_o,
  output logic              busy_o
);
  localparam logic [STEP_W-1:0] LAST_PUSH = STEP_W'(CTX_BYTES - 1);
  localparam logic [STEP_W-1:0] POP_TAIL  = STEP_W'(CTX_BYTES);

  seq_st_t           st_d, st_q;
  logic [STEP_W-1:0] step_d, step_q;
  ctx_t              snap_q;
  logic [VEC_W-1:0]  vec_q;
  logic              ldv_q;
  logic [SEL_W-1:0]  lds_q;
  logic              in_push, in_pop;

  // Next-state process
  always_comb begin
    st_d    = st_q;
    step_d  = step_q;
    grant_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (ret_i) begin
          st_d   = ST_POP;
          step_d = '0;
        end else if (any_i) begin
          grant_o = 1'b1;
          st_d    = ST_PUSH;
          step_d  = '0;
        end
      end
      ST_PUSH: begin
        if (step_q == LAST_PUSH) st_d = ST_IDLE;
        else                     step_d = step_q + 1'b1;
      end
      ST_POP: begin
        if (step_q == POP_TAIL) st_d = ST_IDLE;
        else                    step_d = step_q + 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
    end
  end

  // Context snapshot and vector, enabled by the grant
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      vec_q  <= '0;
    end else if (grant_o) begin
      snap_q <= ctx_i;
      vec_q  <= idx_i;
    end
  end

  assign in_push = (st_q == ST_PUSH);
  assign in_pop  = (st_q == ST_POP);

  assign re_o = in_pop && (step_q < POP_TAIL);

  // Restore tag trails each pop by one cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ldv_q <= 1'b0;
      lds_q <= '0;
    end else begin
      ldv_q <= re_o;
      if (re_o) lds_q <= step_q[SEL_W-1:0];
    end
  end

  // Push order is the reverse of the register codes
  assign we_o        = in_push;
  assign wdata_o     = ctx_byte(snap_q, SEL_W'(CTX_BYTES - 1) - step_q[SEL_W-1:0]);
  assign set_mask_o  = in_push && (step_q == LAST_PUSH);
  assign vec_valid_o = in_push && (step_q == '0);
  assign vec_o       = vec_q;
  assign ld_valid_o  = ldv_q;
  assign ld_sel_o    = lds_q;
  assign ld_data_o   = rdata_i;
  assign busy_o      = (st_q != ST_IDLE);
endmodule

// File: rtl/irq_ctx_stacker.sv
module irq_ctx_stacker
  import irq_pkg::*;
#(
  parameter int N_SRC = 4,
  localparam int VEC_W = $clog2(N_SRC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_req_i,
  input  logic              trap_req_i,
  input  logic              mask_i,
  input  logic              ret_i,
  input  logic [BYTE_W-1:0] acc_i,
  input  logic [BYTE_W-1:0] xr_i,
  input  logic [BYTE_W-1:0] cc_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [BYTE_W-1:0] stk_rdata_i,
  output logic              stk_we_o,
  output logic [BYTE_W-1:0] stk_wdata_o,
  output logic              stk_re_o,
  output logic              ld_valid_o,
  output logic [SEL_W-1:0]  ld_sel_o,
  output logic [BYTE_W-1:0] ld_data_o,
  output logic              vec_valid_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              set_mask_o,
  output logic              busy_o
);
  logic [N_SRC:0]   pend, clr, onehot;
  logic             any, grant;
  logic [VEC_W-1:0] idx;
  ctx_t             ctx;

  assign ctx = '{cc: cc_i, a: acc_i, x: xr_i, pc: pc_i};
  assign clr = grant ? onehot : '0;

  irq_pend_latch #(.N(N_SRC + 1)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  ({trap_req_i, irq_req_i}),
    .clr_i  (clr),
    .pend_o (pend)
  );

  irq_pick #(.N_SRC(N_SRC)) u_pick (
    .pend_i   (pend),
    .mask_i   (mask_i),
    .any_o    (any),
    .idx_o    (idx),
    .onehot_o (onehot)
  );

  ctx_seq #(.VEC_W(VEC_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .any_i       (any),
    .idx_i       (idx),
    .ret_i       (ret_i),
    .ctx_i       (ctx),
    .rdata_i     (stk_rdata_i),
    .grant_o     (grant),
    .we_o        (stk_we_o),
    .wdata_o     (stk_wdata_o),
    .re_o        (stk_re_o),
    .ld_valid_o  (ld_valid_o),
    .ld_sel_o    (ld_sel_o),
    .ld_data_o   (ld_data_o),
    .vec_valid_o (vec_valid_o),
    .vec_o       (vec_o),
    .set_mask_o  (set_mask_o),
    .busy_o      (busy_o)
  );
endmodule

// File: rtl/irq_ctx_chk.sv
module irq_ctx_chk
  import irq_pkg::*;
#(
  parameter int N_SRC = 4,
  localparam int VEC_W = $clog2(N_SRC + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_SRC-1:0]  irq_req_i,
  input logic              trap_req_i,
  input logic              mask_i,
  input logic              ret_i,
  input logic [BYTE_W-1:0] acc_i,
  input logic [BYTE_W-1:0] xr_i,
  input logic [BYTE_W-1:0] cc_i,
  input logic [PC_W-1:0]   pc_i,
  input logic [BYTE_W-1:0] stk_rdata_i,
  input logic              stk_we_o,
  input logic [BYTE_W-1:0] stk_wdata_o,
  input logic              stk_re_o,
  input logic              ld_valid_o,
  input logic [SEL_W-1:0]  ld_sel_o,
  input logic [BYTE_W-1:0] ld_data_o,
  input logic              vec_valid_o,
  input logic [VEC_W-1:0]  vec_o,
  input logic              set_mask_o,
  input logic              busy_o
);
  // R2/R3: a maskable accept needs the mask low in the accept cycle
  p_masked_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> (!$past(mask_i) || vec_o == VEC_W'(N_SRC)));

  // R6: a push run continues until the CC push
  p_push_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_we_o && !set_mask_o) |=> stk_we_o);

  // R7: mask request only alongside a push
  p_mask_with_cc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_mask_o |-> stk_we_o);

  // R7: the push run ends with the mask request
  p_run_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_mask_o |=> !stk_we_o);

  // R9: every pop yields a load next cycle
  p_ld_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stk_re_o |=> ld_valid_o);

  // R9: no load without a pop
  p_ld_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid_o |-> $past(stk_re_o));

  // R10: stack strobes only while busy, never both
  p_strobe_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_we_o || stk_re_o) |-> (busy_o && !(stk_we_o && stk_re_o)));

  // R12: vector report opens a push run
  p_vec_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> (stk_we_o && !$past(stk_we_o)));
endmodule

bind irq_ctx_stacker irq_ctx_chk #(.N_SRC(N_SRC)) u_chk (.*);

// File: tb/sim_irq_ctx_stacker.sv
module sim_irq_ctx_stacker;
  localparam int N = 4;
  localparam int VW = $clog2(N + 1);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq = '0;
  logic         trap = 1'b0, mask = 1'b1, ret = 1'b0;
  logic [7:0]   acc = 8'h00, xr = 8'h00, cc = 8'h00, rdata = 8'h00;
  logic [15:0]  pc = 16'h0000;
  logic         we, re, ldv, vv, sm, busy;
  logic [7:0]   wd, ldd;
  logic [2:0]   lds;
  logic [VW-1:0] vec;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [8:0] wq[$];   // {set_mask flag, byte}
  int         vq[$];
  logic [10:0] lq[$];  // {sel, byte}

  logic [7:0] stk_mem [0:63];
  int sp = 63;

  always #4 clk = ~clk;

  irq_ctx_stacker #(.N_SRC(N)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_req_i(irq), .trap_req_i(trap),
    .mask_i(mask), .ret_i(ret), .acc_i(acc), .xr_i(xr), .cc_i(cc),
    .pc_i(pc), .stk_rdata_i(rdata), .stk_we_o(we), .stk_wdata_o(wd),
    .stk_re_o(re), .ld_valid_o(ldv), .ld_sel_o(lds), .ld_data_o(ldd),
    .vec_valid_o(vv), .vec_o(vec), .set_mask_o(sm), .busy_o(busy));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Core model: mask set on request; stack memory with one-cycle read
  always @(posedge clk) begin
    if (sm) mask <= 1'b1;
    if (we) begin
      stk_mem[sp] <= wd;
      sp <= (sp - 1) & 63;
    end
    if (re) begin
      rdata <= stk_mem[(sp + 1) & 63];
      sp <= (sp + 1) & 63;
    end
  end

  // Monitor: compares design output with the scoreboard queues
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (we) begin
        if (wq.size() == 0) check(0, "R6 unexpected push", int'(wd), 0);
        else begin
          logic [8:0] e;
          e = wq.pop_front();
          check(wd == e[7:0], "R6 push byte", int'(wd), int'(e[7:0]));
          check(sm == e[8], "R7 set_mask with CC push", int'(sm), int'(e[8]));
        end
      end else if (sm) check(0, "R7 set_mask without push", 1, 0);
      if (vv) begin
        if (vq.size() == 0) check(0, "R12 unexpected accept", int'(vec), -1);
        else begin
          int ev;
          ev = vq.pop_front();
          check(int'(vec) == ev, "R3/R4 R12 vector index", int'(vec), ev);
        end
      end
      if (ldv) begin
        if (lq.size() == 0) check(0, "R9 unexpected load", int'(lds), 0);
        else begin
          logic [10:0] e;
          e = lq.pop_front();
          check({lds, ldd} == e, "R9 load sel/data", int'({lds, ldd}), int'(e));
        end
      end
    end
  end

  // Driver tasks
  task automatic expect_entry(input int v, input logic [7:0] ea, ex, ecc, input logic [15:0] epc);
    vq.push_back(v);
    wq.push_back({1'b0, epc[7:0]});
    wq.push_back({1'b0, epc[15:8]});
    wq.push_back({1'b0, ex});
    wq.push_back({1'b0, ea});
    wq.push_back({1'b1, ecc});
  endtask

  task automatic expect_return(input logic [7:0] ea, ex, ecc, input logic [15:0] epc);
    lq.push_back({3'd0, ecc});
    lq.push_back({3'd1, ea});
    lq.push_back({3'd2, ex});
    lq.push_back({3'd3, epc[15:8]});
    lq.push_back({3'd4, epc[7:0]});
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic settle();
    tick(3);
    while (busy) tick(1);
    tick(2);
  endtask

  task automatic set_ctx(input logic [7:0] a_, x_, c_, input logic [15:0] p_);
    acc = a_; xr = x_; cc = c_; pc = p_;
  endtask

  task automatic pulse_irq(input int i);
    irq[i] = 1'b1; tick(1); irq[i] = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) stk_mem[i] = 8'h00;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    @(negedge clk);
    // R1 reset state
    check({busy, we, re, ldv, vv, sm} == 6'b0, "R1 reset outputs", int'({busy, we, re, ldv, vv, sm}), 0);
    tick(3);
    check(busy == 0, "R1 no pending after reset", int'(busy), 0);

    // R2 masked request held, serviced after unmask
    set_ctx(8'h11, 8'h22, 8'h33, 16'h1234);
    pulse_irq(2);
    tick(10);
    check(busy == 0, "R2 masked request not taken", int'(busy), 0);
    expect_entry(2, 8'h11, 8'h22, 8'h33, 16'h1234);
    mask = 1'b0;
    tick(2);
    // R6 snapshot: change context while busy
    check(busy == 1, "R10 busy during push", int'(busy), 1);
    set_ctx(8'hEE, 8'hEE, 8'hEE, 16'hEEEE);
    settle();
    check(mask == 1, "R7 mask set by entry", int'(mask), 1);

    // R5 repeated requests merge
    set_ctx(8'hA1, 8'hA2, 8'hA3, 16'hBEEF);
    pulse_irq(1); tick(2); pulse_irq(1); tick(1); pulse_irq(1);
    expect_entry(1, 8'hA1, 8'hA2, 8'hA3, 16'hBEEF);
    mask = 1'b0;
    settle();
    mask = 1'b0;
    tick(8);
    check(busy == 0, "R5 merged request serviced once", int'(busy), 0);

    // R4 lowest index wins
    mask = 1'b1;
    set_ctx(8'h44, 8'h55, 8'h66, 16'h7788);
    irq[3] = 1'b1; irq[0] = 1'b1; tick(1); irq = '0;
    expect_entry(0, 8'h44, 8'h55, 8'h66, 16'h7788);
    expect_entry(3, 8'h44, 8'h55, 8'h66, 16'h7788);
    mask = 1'b0;
    settle();
    mask = 1'b0;
    settle();

    // R3 trap bypasses mask and beats pending source
    mask = 1'b1;
    set_ctx(8'h01, 8'h02, 8'h03, 16'h0405);
    pulse_irq(1);
    trap = 1'b1; tick(1); trap = 1'b0;
    expect_entry(N, 8'h01, 8'h02, 8'h03, 16'h0405);
    settle();
    check(mask == 1, "R3 trap taken with mask set", int'(mask), 1);
    expect_entry(1, 8'h01, 8'h02, 8'h03, 16'h0405);
    mask = 1'b0;
    settle();

    // R8 request on the clearing edge re-latches
    mask = 1'b0;
    set_ctx(8'h5A, 8'h6B, 8'h7C, 16'h8D9E);
    expect_entry(2, 8'h5A, 8'h6B, 8'h7C, 16'h8D9E);
    expect_entry(2, 8'h5A, 8'h6B, 8'h7C, 16'h8D9E);
    irq[2] = 1'b1; tick(2); irq[2] = 1'b0;
    settle();
    mask = 1'b0;
    settle();
    check(wq.size() == 0, "R8 second entry from set-wins", wq.size(), 0);

    // R9 return restores last context in CC,A,X,PCH,PCL order
    mask = 1'b1;
    expect_return(8'h5A, 8'h6B, 8'h7C, 16'h8D9E);
    ret = 1'b1; tick(1); ret = 1'b0;
    tick(1);
    check(busy == 1, "R10 busy during pop", int'(busy), 1);
    settle();
    check(lq.size() == 0, "R9 all bytes restored", lq.size(), 0);

    // R11 return beats a same-cycle accept; R10 request during busy latched, ret ignored
    mask = 1'b0;
    set_ctx(8'h90, 8'h91, 8'h92, 16'h9394);
    expect_return(8'h5A, 8'h6B, 8'h7C, 16'h8D9E);
    expect_entry(3, 8'h90, 8'h91, 8'h92, 16'h9394);
    irq[3] = 1'b1; tick(1);
    irq[3] = 1'b0; ret = 1'b1; tick(1); ret = 1'b0;
    check(ldv == 0 && re == 1, "R11 return runs first", int'({ldv, re}), 1);
    while (lq.size() != 0) tick(1);
    tick(3);
    // now pushing vec3: ret and irq[0] during push
    ret = 1'b1; irq[0] = 1'b1; tick(1); ret = 1'b0; irq[0] = 1'b0;
    settle();
    check(lq.size() == 0 && wq.size() == 0, "R11 entry after return", wq.size(), 0);
    expect_entry(0, 8'h90, 8'h91, 8'h92, 16'h9394);
    mask = 1'b0;
    settle();

    check(wq.size() == 0 && vq.size() == 0 && lq.size() == 0, "R10 scoreboard drained",
          wq.size() + vq.size() + lq.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule